// File: doc/BRIEF.md
# NAND Flash Bus Cycle Generator

This block sits behind a small register-mapped request port and turns each access into timed cycles on a raw 8-bit NAND flash bus. Each command or address byte written by software becomes one latch-enabled bus cycle. A data access becomes one or four strobed byte cycles. A read returns the byte or bytes the flash drove during its read strobes. Every bus cycle is divided into three phases: setup, strobe-low and hold. The length of each phase comes from its own field in a configuration register and is counted in system clock cycles.

Software writes the configuration register to set up the block. This register holds the enable bit, the chip-enable level and the three phase lengths, and it can also fire a one-cycle restart pulse towards an external ECC accumulator. Software then issues command, address and data accesses. While bus cycles are running, the request port holds off the next request by keeping its ready signal low. A status register reports the flash ready/busy pin.

Top module: `nfc_cycle_engine`

## Requirements
- R1: After reset, nand_ce_n is 1, both nand_we_n and nand_re_n are 1, nand_cle, nand_ale and ecc_clear are 0, req_ready is 1, and a read of the configuration register (select 0) returns 0x0B77.
- R2: Configuration register fields: enable in bit 15, chip-enable level in bit 11, setup in bits [9:8], strobe in bits [6:4], hold in bits [2:0]. Writes to these fields read back unchanged. nand_ce_n follows bit 11 in the cycle after the write, so writing 1 deselects the flash and writing 0 selects it.
- R3: Each byte cycle starts with a setup phase of (setup field + 1) clocks. During this phase both strobes are inactive and the latch enables and data are already valid.
- R4: The strobe (nand_we_n for writes, nand_re_n for reads) stays low for (strobe field + 1) clocks.
- R5: After the strobe rises, a hold phase of (hold field + 1) clocks keeps nand_cle, nand_ale, nand_dq_oe and nand_dq_out unchanged.
- R6: A write to select 1 produces one write cycle with nand_cle high and nand_ale low. A write to select 2 produces one with nand_ale high and nand_cle low. In both cases the flash sees req_wdata[7:0] on nand_dq_out.
- R7: A write to select 3 with req_wide 0 produces one write cycle with req_wdata[7:0]. With req_wide 1 it produces four back-to-back write cycles carrying bits [7:0], [15:8], [23:16] and [31:24] in that order. Neither latch enable is raised in either case.
- R8: A read of select 3 produces read cycles (one, or four when req_wide is 1). During these cycles nand_dq_oe is 0, and nand_dq_in is captured as nand_re_n rises. The first byte lands in bits [7:0], and the unused upper bits are 0. rsp_valid pulses with the result in the cycle right after the last hold clock.
- R9: Once a bus access is accepted, req_ready stays 0 until the cycle after the last hold clock. Consecutive bytes of a wide access are separated by exactly (hold + 1) + (setup + 1) strobe-inactive clocks.
- R10: A read of select 4 returns nand_rb in bit 0 (1 means ready), with rsp_valid high in the next cycle.
- R11: Writing 1 to configuration bit 12 raises ecc_clear for exactly one cycle, the cycle after the write. Bit 12 always reads back 0.
- R12: While the enable bit is 0, command, address and data accesses produce no bus cycle and req_ready stays 1. A data read in this state returns 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select: 0 config, 1 command, 2 address, 3 data, 4 status |
| req_wide | input | 1 | Data access of four bytes instead of one |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_rdata | output | 32 | Read response data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven to the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Data from the flash |
| nand_rb | input | 1 | Flash ready/busy, 1 = ready |
| ecc_clear | output | 1 | One-cycle ECC restart pulse |

## Verification
The bench checks the length of every phase at the extreme field values, all zero and all maximum. A generator that does not add the encoded plus one would come out one clock short at each of these settings. Wide transfers are checked for byte order and for the inter-byte gap: a byte reversal, or a hold that merges into the next byte's setup, would change either the data seen per strobe or the number of idle clocks. The bench also checks that the ECC restart pulse lasts a single cycle and is not stored. Finally, it checks that a disabled block emits no strobe at all, which a design that ignores the enable bit would get wrong.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int SEL_W   = 3;
  localparam int SETUP_W = 2;
  localparam int PHASE_W = 3;

  localparam logic [SEL_W-1:0] SEL_CONFIG = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CMD    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADDR   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DATA   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd4;

  typedef enum logic [1:0] {XK_CMD, XK_ADDR, XK_WR, XK_RD} xfer_kind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  typedef struct packed {
    logic               en;
    logic               ce_n;
    logic [SETUP_W-1:0] t_setup;
    logic [PHASE_W-1:0] t_strobe;
    logic [PHASE_W-1:0] t_hold;
  } cfg_t;
endpackage

// File: rtl/nfc_cfg_regs.sv
module nfc_cfg_regs
  import nfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output cfg_t        cfg,
  output logic        ecc_clr,
  output logic [15:0] rd_word
);
  cfg_t cfg_q, cfg_d;
  logic ecc_q, ecc_d;

  always_comb begin
    cfg_d = cfg_q;
    ecc_d = 1'b0;
    if (wr_en) begin
      cfg_d.en       = wdata[15];
      cfg_d.ce_n     = wdata[11];
      cfg_d.t_setup  = wdata[9:8];
      cfg_d.t_strobe = wdata[6:4];
      cfg_d.t_hold   = wdata[2:0];
      ecc_d          = wdata[12];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.en       <= 1'b0;
      cfg_q.ce_n     <= 1'b1;
      cfg_q.t_setup  <= '1;
      cfg_q.t_strobe <= '1;
      cfg_q.t_hold   <= '1;
      ecc_q          <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ecc_q <= ecc_d;
    end
  end

  assign cfg     = cfg_q;
  assign ecc_clr = ecc_q;
  assign rd_word = {cfg_q.en, 3'b000, cfg_q.ce_n, 1'b0, cfg_q.t_setup,
                    1'b0, cfg_q.t_strobe, 1'b0, cfg_q.t_hold};

  // R11: restart pulse never lasts two cycles
  a_r11_ecc_single: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |=> !ecc_clr);
endmodule

// File: rtl/nfc_phase_timer.sv
module nfc_phase_timer
  import nfc_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  xfer_kind_e         start_kind,
  input  logic [BUS_W-1:0]   start_byte,
  input  logic [SETUP_W-1:0] t_setup,
  input  logic [PHASE_W-1:0] t_strobe,
  input  logic [PHASE_W-1:0] t_hold,
  output logic               active,
  output logic               done,
  output logic               cap,
  output logic               cle,
  output logic               ale,
  output logic               we_n,
  output logic               re_n,
  output logic [BUS_W-1:0]   dq_out,
  output logic               dq_oe
);
  localparam int CNT_W = (SETUP_W > PHASE_W) ? SETUP_W : PHASE_W;

  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  xfer_kind_e        kind_q, kind_d;
  logic [BUS_W-1:0]  byte_q, byte_d;
  logic              last, strobe, in_cyc;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    byte_d  = byte_q;
    case (state_q)
      PH_IDLE: if (start) begin
        state_d = PH_SETUP;
        cnt_d   = CNT_W'(t_setup);
        kind_d  = start_kind;
        byte_d  = start_byte;
      end
      PH_SETUP: if (last) begin
        state_d = PH_STROBE;
        cnt_d   = CNT_W'(t_strobe);
      end else cnt_d = cnt_q - 1'b1;
      PH_STROBE: if (last) begin
        state_d = PH_HOLD;
        cnt_d   = CNT_W'(t_hold);
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (last) begin
        if (start) begin
          state_d = PH_SETUP;
          cnt_d   = CNT_W'(t_setup);
          kind_d  = start_kind;
          byte_d  = start_byte;
        end else state_d = PH_IDLE;
      end else cnt_d = cnt_q - 1'b1;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      kind_q  <= XK_CMD;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      byte_q  <= byte_d;
    end
  end

  assign in_cyc = (state_q != PH_IDLE);
  assign strobe = (state_q == PH_STROBE);
  assign active = in_cyc;
  assign done   = (state_q == PH_HOLD) && last;
  assign cap    = strobe && last && (kind_q == XK_RD);
  assign cle    = in_cyc && (kind_q == XK_CMD);
  assign ale    = in_cyc && (kind_q == XK_ADDR);
  assign we_n   = !(strobe && (kind_q != XK_RD));
  assign re_n   = !(strobe && (kind_q == XK_RD));
  assign dq_oe  = in_cyc && (kind_q != XK_RD);
  assign dq_out = dq_oe ? byte_q : '0;

  // R6: the two latch enables are never raised together
  a_r6_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R8: the block never drives the bus while the read strobe is low
  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);
  // R5: signals stay put throughout the hold phase
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HOLD && !last) |=>
      ($stable(cle) && $stable(ale) && $stable(dq_out) && we_n && re_n));
  // R3: a strobe phase is always entered from a setup phase
  a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(state_q) != PH_STROBE) |-> $past(state_q) == PH_SETUP);
endmodule

// File: rtl/nfc_cycle_engine.sv
module nfc_cycle_engine
  import nfc_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int WORD_BYTES = 4,
  parameter bit WIDE_EN    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [SEL_W-1:0]            req_sel,
  input  logic                        req_wide,
  input  logic [BUS_W*WORD_BYTES-1:0] req_wdata,
  output logic                        rsp_valid,
  output logic [BUS_W*WORD_BYTES-1:0] rsp_rdata,
  output logic                        nand_cle,
  output logic                        nand_ale,
  output logic                        nand_ce_n,
  output logic                        nand_we_n,
  output logic                        nand_re_n,
  output logic [BUS_W-1:0]            nand_dq_out,
  output logic                        nand_dq_oe,
  input  logic [BUS_W-1:0]            nand_dq_in,
  input  logic                        nand_rb,
  output logic                        ecc_clear
);
  localparam int WORD_W = BUS_W * WORD_BYTES;
  localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  cfg_t        cfg;
  logic [15:0] cfg_word;
  logic        cfg_we;

  nfc_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_we),
    .wdata   (req_wdata[15:0]),
    .cfg     (cfg),
    .ecc_clr (ecc_clear),
    .rd_word (cfg_word)
  );

  logic       wide_ok;
  generate
    if (WIDE_EN) begin : g_wide
      assign wide_ok = req_wide;
    end else begin : g_narrow
      assign wide_ok = 1'b0;
    end
  endgenerate

  logic             t_active, t_done, t_cap, t_start;
  xfer_kind_e       t_kind, new_kind, kind_q, kind_d;
  logic [BUS_W-1:0] t_byte;

  logic              accept, is_bus, more;
  logic [IDX_W-1:0]  left_q, left_d, idx_q, idx_d, nb_m1;
  logic [WORD_W-1:0] wbuf_q, wbuf_d, wnext, rdbuf_q, rdbuf_d;
  logic              rd_pend_q, rd_pend_d, rsp_v_q, rsp_v_d;
  logic [WORD_W-1:0] rsp_q, rsp_d;

  assign req_ready = !t_active;
  assign accept    = req_valid && req_ready;
  assign cfg_we    = accept && req_write && (req_sel == SEL_CONFIG);
  assign is_bus    = accept && cfg.en &&
                     ((req_write && (req_sel == SEL_CMD || req_sel == SEL_ADDR ||
                                     req_sel == SEL_DATA)) ||
                      (!req_write && req_sel == SEL_DATA));
  assign nb_m1     = (wide_ok && req_sel == SEL_DATA) ? IDX_W'(WORD_BYTES - 1) : '0;
  assign more      = (left_q != '0);
  assign wnext     = wbuf_q >> BUS_W;

  always_comb begin
    case (req_sel)
      SEL_CMD:  new_kind = XK_CMD;
      SEL_ADDR: new_kind = XK_ADDR;
      default:  new_kind = req_write ? XK_WR : XK_RD;
    endcase
  end

  assign t_start = is_bus || (t_done && more);
  assign t_kind  = is_bus ? new_kind : kind_q;
  assign t_byte  = is_bus ? req_wdata[BUS_W-1:0] : wnext[BUS_W-1:0];

  always_comb begin
    left_d    = left_q;
    idx_d     = idx_q;
    wbuf_d    = wbuf_q;
    rdbuf_d   = rdbuf_q;
    rd_pend_d = rd_pend_q;
    kind_d    = kind_q;
    rsp_v_d   = 1'b0;
    rsp_d     = rsp_q;
    for (int l = 0; l < WORD_BYTES; l++) begin
      if (t_cap && idx_q == IDX_W'(l)) rdbuf_d[l*BUS_W +: BUS_W] = nand_dq_in;
    end
    if (t_done) begin
      if (more) begin
        left_d = left_q - 1'b1;
        idx_d  = idx_q + 1'b1;
        wbuf_d = wnext;
      end else if (rd_pend_q) begin
        rsp_v_d   = 1'b1;
        rsp_d     = rdbuf_q;
        rd_pend_d = 1'b0;
      end
    end
    if (is_bus) begin
      left_d    = nb_m1;
      idx_d     = '0;
      wbuf_d    = req_wdata;
      rdbuf_d   = '0;
      rd_pend_d = !req_write;
      kind_d    = new_kind;
    end else if (accept && !req_write) begin
      rsp_v_d = 1'b1;
      case (req_sel)
        SEL_CONFIG: rsp_d = WORD_W'(cfg_word);
        SEL_STATUS: rsp_d = WORD_W'(nand_rb);
        default:    rsp_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      left_q    <= '0;
      idx_q     <= '0;
      wbuf_q    <= '0;
      rdbuf_q   <= '0;
      rd_pend_q <= 1'b0;
      kind_q    <= XK_CMD;
      rsp_v_q   <= 1'b0;
      rsp_q     <= '0;
    end else begin
      left_q    <= left_d;
      idx_q     <= idx_d;
      wbuf_q    <= wbuf_d;
      rdbuf_q   <= rdbuf_d;
      rd_pend_q <= rd_pend_d;
      kind_q    <= kind_d;
      rsp_v_q   <= rsp_v_d;
      rsp_q     <= rsp_d;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_q;
  assign nand_ce_n = cfg.ce_n;

  nfc_phase_timer #(.BUS_W(BUS_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (t_start),
    .start_kind (t_kind),
    .start_byte (t_byte),
    .t_setup    (cfg.t_setup),
    .t_strobe   (cfg.t_strobe),
    .t_hold     (cfg.t_hold),
    .active     (t_active),
    .done       (t_done),
    .cap        (t_cap),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .dq_out     (nand_dq_out),
    .dq_oe      (nand_dq_oe)
  );

  // R9: an accepted bus access blocks the port in the following cycle
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_int_n)
    is_bus |=> !req_ready);
  // R12: no strobe while the block is disabled
  a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg.en |-> (nand_we_n && nand_re_n));
  // R8: a response never appears while bytes are still in flight
  a_r8_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> !t_active || $past(t_done));
endmodule

// File: tb/nfc_cycle_engine_tb_top.sv
module nfc_cycle_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_wide;
  logic [2:0]  req_sel;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out, nand_dq_in;
  logic        nand_rb, ecc_clear;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nfc_cycle_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wide(req_wide),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
    .ecc_clear(ecc_clear)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_val(input bit en, input bit ce_n,
      input int t, input int p0, input int p1);
    return (32'(en) << 15) | (32'(ce_n) << 11) | (32'(t) << 8) |
           (32'(p0) << 4) | 32'(p1);
  endfunction

  task automatic issue(input bit wr, input logic [2:0] sel, input bit wide,
                       input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_wide = wide; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] sel, output logic [31:0] d,
                          output logic v);
    issue(1'b0, sel, 1'b0, 32'h0);
    d = rsp_rdata; v = rsp_valid;
  endtask

  // op: 0 cmd, 1 addr, 2 byte write, 3 wide write, 4 byte read, 5 wide read
  task automatic bus_op(input int op, input logic [31:0] d, input int t,
                        input int p0, input int p1);
    logic [2:0] sel;
    bit wr, wide, bad_lvl, bad_dq, cur_s, s;
    int nb, nr, k, cyc;
    int runs[16];
    logic [31:0] exp_rd;
    sel  = (op == 0) ? 3'd1 : (op == 1) ? 3'd2 : 3'd3;
    wr   = (op < 4);
    wide = (op == 3) || (op == 5);
    nb   = wide ? 4 : 1;
    bad_lvl = 0; bad_dq = 0; nr = 0; k = -1; cyc = 0; cur_s = 0;
    issue(wr, sel, wide, d);
    while (!req_ready && cyc < 400) begin
      s = !nand_we_n || !nand_re_n;
      if (nr == 0 || s != cur_s) begin
        if (nr < 16) runs[nr] = 0;
        nr++;
        cur_s = s;
        if (s) begin
          k++;
          if (!wr) nand_dq_in = d[8*(k%4) +: 8];
        end
      end
      if (nr <= 16) runs[nr-1]++;
      if (nand_cle != (op == 0) || nand_ale != (op == 1)) bad_lvl = 1;
      if (nand_dq_oe != wr) bad_lvl = 1;
      if (wr && !nand_re_n) bad_lvl = 1;
      if (!wr && !nand_we_n) bad_lvl = 1;
      if (s && wr && nand_dq_out != d[8*(k%4) +: 8]) bad_dq = 1;
      cyc++;
      @(negedge clk);
    end
    chk(nr == 2*nb + 1, "R7/R8 byte cycle count", 32'(nr), 32'(2*nb + 1));
    chk(!bad_lvl, "R6 latch enables and bus direction", 32'(bad_lvl), 32'h0);
    if (wr) chk(!bad_dq, "R7 byte value and order on strobe", 32'(bad_dq), 32'h0);
    if (nr == 2*nb + 1) begin
      chk(runs[0] == t + 1, "R3 setup length", 32'(runs[0]), 32'(t + 1));
      for (int i = 0; i < nb; i++)
        chk(runs[2*i+1] == p0 + 1, "R4 strobe length", 32'(runs[2*i+1]), 32'(p0 + 1));
      for (int i = 1; i < nb; i++)
        chk(runs[2*i] == p1 + t + 2, "R9 gap between bytes", 32'(runs[2*i]),
            32'(p1 + t + 2));
      chk(runs[2*nb] == p1 + 1, "R5 hold length", 32'(runs[2*nb]), 32'(p1 + 1));
    end
    chk(cyc == nb*(t + p0 + p1 + 3), "R9 ready low span", 32'(cyc),
        32'(nb*(t + p0 + p1 + 3)));
    if (wr) chk(rsp_valid == 1'b0, "R8 no response on write", 32'(rsp_valid), 32'h0);
    else begin
      exp_rd = wide ? d : {24'h0, d[7:0]};
      chk(rsp_valid == 1'b1, "R8 response valid", 32'(rsp_valid), 32'h1);
      chk(rsp_rdata == exp_rd, "R8 read data", rsp_rdata, exp_rd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic v;
    int t, p0, p1, op;
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_sel = 3'd0;
    req_wide = 1'b0; req_wdata = 32'h0; nand_dq_in = 8'h0; nand_rb = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(nand_ce_n == 1'b1, "R1 nce after reset", 32'(nand_ce_n), 32'h1);
    chk(nand_we_n && nand_re_n, "R1 strobes idle", {nand_we_n, nand_re_n}, 32'h3);
    chk(!nand_cle && !nand_ale && !ecc_clear, "R1 latches low",
        {nand_cle, nand_ale, ecc_clear}, 32'h0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
    reg_read(3'd0, rd, v);
    chk(v && rd == 32'h0B77, "R1 config reset value", rd, 32'h0B77);

    // R12 disabled: no cycle, data read returns zero at once
    issue(1'b1, 3'd1, 1'b0, 32'h0000_0070);
    begin
      bit quiet = 1;
      for (int i = 0; i < 12; i++) begin
        if (!nand_we_n || nand_cle || !req_ready) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R12 disabled command ignored", 32'(quiet), 32'h1);
    end
    reg_read(3'd3, rd, v);
    chk(v && rd == 32'h0, "R12 disabled data read", rd, 32'h0);

    // R2 field readback and chip enable level
    issue(1'b1, 3'd0, 1'b0, cfg_val(1, 0, 2, 5, 1));
    chk(nand_ce_n == 1'b0, "R2 nce follows bit 11", 32'(nand_ce_n), 32'h0);
    reg_read(3'd0, rd, v);
    chk(rd == cfg_val(1, 0, 2, 5, 1), "R2 config readback", rd, cfg_val(1, 0, 2, 5, 1));
    issue(1'b1, 3'd0, 1'b0, cfg_val(1, 1, 2, 5, 1));
    chk(nand_ce_n == 1'b1, "R2 nce deselect", 32'(nand_ce_n), 32'h1);

    // R11 ecc restart pulse
    issue(1'b1, 3'd0, 1'b0, cfg_val(1, 0, 1, 1, 1) | 32'h1000);
    chk(ecc_clear == 1'b1, "R11 pulse present", 32'(ecc_clear), 32'h1);
    @(negedge clk);
    chk(ecc_clear == 1'b0, "R11 pulse one cycle", 32'(ecc_clear), 32'h0);
    reg_read(3'd0, rd, v);
    chk(rd[12] == 1'b0, "R11 bit not stored", rd, cfg_val(1, 0, 1, 1, 1));

    // R10 status
    nand_rb = 1'b0;
    reg_read(3'd4, rd, v);
    chk(v && rd == 32'h0, "R10 busy", rd, 32'h0);
    nand_rb = 1'b1;
    reg_read(3'd4, rd, v);
    chk(v && rd == 32'h1, "R10 ready", rd, 32'h1);

    // directed corners: minimum and maximum timing
    issue(1'b1, 3'd0, 1'b0, cfg_val(1, 0, 0, 0, 0));
    bus_op(0, 32'h0000_00A5, 0, 0, 0);
    bus_op(1, 32'h0000_003C, 0, 0, 0);
    bus_op(3, 32'h1122_3344, 0, 0, 0);
    bus_op(5, 32'hDEAD_BEEF, 0, 0, 0);
    issue(1'b1, 3'd0, 1'b0, cfg_val(1, 0, 3, 7, 7));
    bus_op(3, 32'hA1B2_C3D4, 3, 7, 7);
    bus_op(5, 32'h0F1E_2D3C, 3, 7, 7);
    bus_op(4, 32'hFFFF_FF81, 3, 7, 7);
    bus_op(2, 32'h0000_0042, 3, 7, 7);

    // constrained random
    for (int it = 0; it < 150; it++) begin
      t  = int'($urandom_range(3, 0));
      p0 = int'($urandom_range(7, 0));
      p1 = int'($urandom_range(7, 0));
      op = int'($urandom_range(5, 0));
      issue(1'b1, 3'd0, 1'b0, cfg_val(1, 0, t, p0, p1));
      bus_op(op, $urandom, t, p0, p1);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule